// File: doc/BRIEF.md
# Thermal Threshold Successive Approximation Engine

This block pairs a digital thermal threshold comparator with a hardware sequencer that finds the junction temperature code without software help. The comparator owns one threshold register. The register holds a 7-bit threshold code, an interrupt-enable field, a valid flag and a result flag. After each threshold write the valid flag clears. It sets again once a programmable settle time has passed, and at that point the result flag captures whether the digital temperature input is at or above the threshold.

On a start request the sequencer runs a binary search over the threshold code. It writes a trial value, waits for the valid flag, reads the result and keeps or drops the trial bit. After seven comparisons it reports the resolved code together with a one-cycle done pulse. While a search runs, the interrupt-enable field is forced to zero so the search never raises a thermal interrupt.

The comparator only works while it has a clock. It runs in the run, nap and doze power modes. In sleep mode it runs only while the system clock is reported present. If the comparator stops during a search, the search aborts with an error pulse.

Top module: `thermsa_top`

## Requirements
- R1: After synchronous reset all outputs read 0: busy_o, done_o, err_o, code_o, thr_code_o, thr_ie_o, thr_valid_o, thr_result_o and thermal_irq_o.
- R2: A start_i pulse while idle and while the comparator is active sets busy_o on the next cycle. The first trial threshold written is 64, which is bit 6 of the 7-bit code.
- R3: Every threshold write clears thr_valid_o on the following cycle. While the comparator is active, thr_valid_o sets settle_i+1 cycles after the write edge. At that point thr_result_o is 1 exactly when temp_i >= thr_code_o.
- R4: The sequencer acts on a result only after thr_valid_o reads 1. Each trial is the code resolved so far with the next lower bit set. A trial bit is kept only when the result is 1.
- R5: After 7 comparisons done_o pulses for one cycle and busy_o falls in that same cycle. code_o then holds the resolved code, which equals temp_i when temp_i is held constant during the search.
- R6: thr_ie_o is 0 while busy_o is 1. While idle it follows irq_en_i one cycle late. thermal_irq_o = thr_ie_o & thr_valid_o & thr_result_o.
- R7: A start_i pulse during a running search has no effect on the trial sequence or on the final code.
- R8: The comparator is active in power modes 0 (run), 1 (nap) and 2 (doze) whatever the value of sysclk_live_i. In mode 3 (sleep) it is active only while sysclk_live_i is 1.
- R9: In mode 3 with sysclk_live_i at 0, thr_valid_o never sets. If this happens during a search, the search aborts: err_o pulses for one cycle, busy_o falls and code_o keeps its previous value.
- R10: A start_i pulse while idle and while the comparator is inactive starts no search and gives a one-cycle err_o pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Search start request |
| temp_i | input | 7 | Digital junction temperature code |
| pwr_mode_i | input | 2 | Power mode: 0 run, 1 nap, 2 doze, 3 sleep |
| sysclk_live_i | input | 1 | System clock present indication |
| settle_i | input | 4 | Settle cycles minus one after a threshold write |
| irq_en_i | input | 1 | Interrupt enable for idle threshold monitoring |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when a search completes |
| err_o | output | 1 | One-cycle pulse on abort or rejected start |
| code_o | output | 7 | Last resolved temperature code |
| thr_code_o | output | 7 | Current threshold register code |
| thr_ie_o | output | 1 | Threshold interrupt-enable field |
| thr_valid_o | output | 1 | Threshold comparison valid flag |
| thr_result_o | output | 1 | Threshold comparison result flag |
| thermal_irq_o | output | 1 | Thermal interrupt request |

## Verification
The search is run with temperatures at both ends of the code range (0 and 127), on either side of the midpoint (63 and 64) and at an irregular value. This separates a wrong first trial, a wrong bit-keep decision and an off-by-one in the final bit. Settle times of zero and several cycles show whether the sequencer really waits for the valid flag rather than for a fixed delay. Running the search in nap, doze and live sleep modes, and then dropping the clock in sleep mid-search, separates the mode gating from the abort path. Extra start pulses during a search, a start while the comparator is inactive, and interrupt enable held high show that starts are ignored while busy and that the interrupt is masked only while the sequencer owns the register.

// File: rtl/thermsa_pkg.sv
package thermsa_pkg;
  localparam int unsigned MODE_W = 2;
  localparam logic [MODE_W-1:0] PM_RUN   = 2'd0;
  localparam logic [MODE_W-1:0] PM_NAP   = 2'd1;
  localparam logic [MODE_W-1:0] PM_DOZE  = 2'd2;
  localparam logic [MODE_W-1:0] PM_SLEEP = 2'd3;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LOAD = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_e;
endpackage

// File: rtl/thermsa_gate.sv
module thermsa_gate
  import thermsa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] pwr_mode_i,
  input  logic              sysclk_live_i,
  output logic              active_o
);
  // Comparator runs unless sleeping with a static system clock.
  assign active_o = (pwr_mode_i != PM_SLEEP) || sysclk_live_i;

  // R8
  awake_modes_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_mode_i != PM_SLEEP) |-> active_o);
endmodule

// File: rtl/thermsa_cmp.sv
module thermsa_cmp #(
  parameter int unsigned CODE_W   = 7,
  parameter int unsigned SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                active_i,
  input  logic [CODE_W-1:0]   temp_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                wr_en_i,
  input  logic [CODE_W-1:0]   wr_code_i,
  input  logic                ie_next_i,
  output logic [CODE_W-1:0]   thr_code_o,
  output logic                thr_ie_o,
  output logic                thr_valid_o,
  output logic                thr_result_o
);
  logic [CODE_W-1:0]   code_q;
  logic                ie_q;
  logic                valid_q;
  logic                result_q;
  logic [SETTLE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q   <= '0;
      ie_q     <= 1'b0;
      valid_q  <= 1'b0;
      result_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      ie_q <= ie_next_i;
      if (wr_en_i) begin
        code_q  <= wr_code_i;
        valid_q <= 1'b0;
        cnt_q   <= '0;
      end else if (active_i && !valid_q) begin
        if (cnt_q >= settle_i) begin
          valid_q  <= 1'b1;
          result_q <= (temp_i >= code_q);
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign thr_code_o   = code_q;
  assign thr_ie_o     = ie_q;
  assign thr_valid_o  = valid_q;
  assign thr_result_o = result_q;

  // R3
  wr_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> !valid_q);

  // R9
  dead_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (!active_i && !wr_en_i && !valid_q) |=> !valid_q);

  // R3
  valid_result_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid_q && !wr_en_i && active_i && cnt_q >= settle_i)
      |=> (valid_q && (result_q == ($past(temp_i) >= code_q))));
endmodule

// File: rtl/thermsa_seq.sv
module thermsa_seq
  import thermsa_pkg::*;
#(
  parameter int unsigned CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              active_i,
  input  logic              irq_en_i,
  input  logic              valid_i,
  input  logic              result_i,
  input  logic [CODE_W-1:0] thr_code_i,
  output logic              wr_en_o,
  output logic [CODE_W-1:0] wr_code_o,
  output logic              ie_next_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned BIT_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(CODE_W - 1);

  sq_state_e         state_q;
  logic [CODE_W-1:0] acc_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CODE_W-1:0] acc_next;
  logic              start_ok;

  assign start_ok  = (state_q == SQ_IDLE) && start_i && active_i;
  assign wr_en_o   = (state_q == SQ_LOAD) && active_i;
  assign wr_code_o = acc_q | (CODE_W'(1) << bit_q);
  assign acc_next  = result_i ? thr_code_i : acc_q;
  // Interrupt masked from the accepting edge until the sequencer is idle again.
  assign ie_next_o = irq_en_i && (state_q == SQ_IDLE) && !start_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      acc_q   <= '0;
      bit_q   <= '0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      code_o  <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (start_i) begin
            if (active_i) begin
              state_q <= SQ_LOAD;
              busy_o  <= 1'b1;
              acc_q   <= '0;
              bit_q   <= TOP_BIT;
            end else begin
              err_o <= 1'b1;
            end
          end
        end
        SQ_LOAD, SQ_WAIT: begin
          if (!active_i) begin
            state_q <= SQ_IDLE;
            busy_o  <= 1'b0;
            err_o   <= 1'b1;
          end else if (state_q == SQ_LOAD) begin
            state_q <= SQ_WAIT;
          end else if (valid_i) begin
            acc_q <= acc_next;
            if (bit_q == '0) begin
              state_q <= SQ_IDLE;
              busy_o  <= 1'b0;
              done_o  <= 1'b1;
              code_o  <= acc_next;
            end else begin
              bit_q   <= bit_q - 1'b1;
              state_q <= SQ_LOAD;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // R4
  hold_until_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_WAIT && !valid_i && active_i) |=> $stable(acc_q));

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R9
  abort_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != SQ_IDLE && !active_i) |=> (err_o && !busy_o));

  // R5
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_o, err_o}));
endmodule

// File: rtl/thermsa_top.sv
module thermsa_top
  import thermsa_pkg::*;
#(
  parameter int unsigned CODE_W   = 7,
  parameter int unsigned SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [CODE_W-1:0]   temp_i,
  input  logic [1:0]          pwr_mode_i,
  input  logic                sysclk_live_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                irq_en_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o,
  output logic [CODE_W-1:0]   code_o,
  output logic [CODE_W-1:0]   thr_code_o,
  output logic                thr_ie_o,
  output logic                thr_valid_o,
  output logic                thr_result_o,
  output logic                thermal_irq_o
);
  logic              active;
  logic              wr_en;
  logic [CODE_W-1:0] wr_code;
  logic              ie_next;

  thermsa_gate u_gate (
    .clk           (clk),
    .rst           (rst),
    .pwr_mode_i    (pwr_mode_i),
    .sysclk_live_i (sysclk_live_i),
    .active_o      (active)
  );

  thermsa_cmp #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) u_cmp (
    .clk          (clk),
    .rst          (rst),
    .active_i     (active),
    .temp_i       (temp_i),
    .settle_i     (settle_i),
    .wr_en_i      (wr_en),
    .wr_code_i    (wr_code),
    .ie_next_i    (ie_next),
    .thr_code_o   (thr_code_o),
    .thr_ie_o     (thr_ie_o),
    .thr_valid_o  (thr_valid_o),
    .thr_result_o (thr_result_o)
  );

  thermsa_seq #(.CODE_W(CODE_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .active_i   (active),
    .irq_en_i   (irq_en_i),
    .valid_i    (thr_valid_o),
    .result_i   (thr_result_o),
    .thr_code_i (thr_code_o),
    .wr_en_o    (wr_en),
    .wr_code_o  (wr_code),
    .ie_next_o  (ie_next),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .code_o     (code_o)
  );

  assign thermal_irq_o = thr_ie_o && thr_valid_o && thr_result_o;

  // R6
  search_masks_irq_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (!thr_ie_o && !thermal_irq_o));
endmodule

// File: tb/tb_thermsa_top.sv
module tb_thermsa_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [6:0] temp_i = '0;
  logic [1:0] pwr_mode_i = 2'd0;
  logic       sysclk_live_i = 1'b1;
  logic [3:0] settle_i = '0;
  logic       irq_en_i = 1'b0;
  logic       busy_o, done_o, err_o, thr_ie_o, thr_valid_o, thr_result_o, thermal_irq_o;
  logic [6:0] code_o, thr_code_o;

  thermsa_top dut (
    .clk(clk), .rst(rst), .start_i(start_i), .temp_i(temp_i),
    .pwr_mode_i(pwr_mode_i), .sysclk_live_i(sysclk_live_i), .settle_i(settle_i),
    .irq_en_i(irq_en_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .code_o(code_o), .thr_code_o(thr_code_o), .thr_ie_o(thr_ie_o),
    .thr_valid_o(thr_valid_o), .thr_result_o(thr_result_o),
    .thermal_irq_o(thermal_irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // Behavioural reference: phase 0 idle, 1 write pending, 2 awaiting valid.
  int m_ph = 0, m_acc = 0, m_bit = 0, m_thr = 0, m_cnt = 0, m_code = 0;
  bit m_ie = 0, m_valid = 0, m_res = 0, m_busy = 0, m_done = 0, m_err = 0;

  always @(posedge clk) begin
    int n_ph, n_acc, n_bit, n_thr, n_cnt, n_code, trial;
    bit n_ie, n_valid, n_res, n_done, n_err, act;
    act = (pwr_mode_i != 2'd3) || sysclk_live_i;
    if (rst) begin
      m_ph = 0; m_acc = 0; m_bit = 0; m_thr = 0; m_cnt = 0; m_code = 0;
      m_ie = 0; m_valid = 0; m_res = 0; m_busy = 0; m_done = 0; m_err = 0;
    end else begin
      n_ph = m_ph; n_acc = m_acc; n_bit = m_bit; n_thr = m_thr; n_cnt = m_cnt;
      n_code = m_code; n_valid = m_valid; n_res = m_res; n_done = 0; n_err = 0;
      trial = m_acc + (1 << m_bit);
      if (m_ph == 1 && act) begin
        n_thr = trial; n_valid = 0; n_cnt = 0;
      end else if (act && !m_valid) begin
        if (m_cnt >= int'(settle_i)) begin
          n_valid = 1; n_res = (int'(temp_i) >= m_thr);
        end else n_cnt = m_cnt + 1;
      end
      n_ie = irq_en_i && m_ph == 0 && !(start_i && act);
      if (m_ph == 0) begin
        if (start_i) begin
          if (act) begin n_ph = 1; n_acc = 0; n_bit = 6; end
          else n_err = 1;
        end
      end else if (!act) begin
        n_ph = 0; n_err = 1;
      end else if (m_ph == 1) begin
        n_ph = 2;
      end else if (m_valid) begin
        n_acc = m_res ? m_thr : m_acc;
        if (m_bit == 0) begin n_ph = 0; n_done = 1; n_code = n_acc; end
        else begin n_bit = m_bit - 1; n_ph = 1; end
      end
      m_ph = n_ph; m_acc = n_acc; m_bit = n_bit; m_thr = n_thr; m_cnt = n_cnt;
      m_code = n_code; m_ie = n_ie; m_valid = n_valid; m_res = n_res;
      m_done = n_done; m_err = n_err; m_busy = (n_ph != 0);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Per-clock comparison against the reference model.
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk(busy_o == m_busy, "R2", "busy_o", busy_o, m_busy);
      chk(thr_code_o == m_thr[6:0], "R4", "thr_code_o", thr_code_o, m_thr);
      chk(thr_valid_o == m_valid, "R3", "thr_valid_o", thr_valid_o, m_valid);
      chk(thr_result_o == m_res, "R3", "thr_result_o", thr_result_o, m_res);
      chk(thr_ie_o == m_ie, "R6", "thr_ie_o", thr_ie_o, m_ie);
      chk(thermal_irq_o == (m_ie && m_valid && m_res), "R6", "thermal_irq_o",
          thermal_irq_o, m_ie && m_valid && m_res);
      chk(done_o == m_done, "R5", "done_o", done_o, m_done);
      chk(code_o == m_code[6:0], "R5", "code_o", code_o, m_code);
      chk(err_o == m_err, "R9", "err_o", err_o, m_err);
    end
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_end(output bit got_done);
    got_done = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (m_done || m_err) begin got_done = m_done; break; end
    end
  endtask

  task automatic search(input int t, input int mode, input int st, input string req);
    bit d;
    temp_i = 7'(t); pwr_mode_i = 2'(mode); settle_i = 4'(st);
    pulse_start();
    wait_end(d);
    chk(d, req, "search completed", d, 1);
    chk(code_o == 7'(t), req, "resolved code", code_o, t);
    chk(busy_o == 1'b0, req, "busy after done", busy_o, 0);
  endtask

  initial begin
    bit d;
    tick(3);
    // R1: reset state
    chk(busy_o == 0 && done_o == 0 && err_o == 0, "R1", "status at reset", busy_o, 0);
    chk(code_o == 0 && thr_code_o == 0, "R1", "codes at reset", thr_code_o, 0);
    chk(thr_valid_o == 0 && thr_result_o == 0 && thr_ie_o == 0 && thermal_irq_o == 0,
        "R1", "threshold fields at reset", thr_valid_o, 0);
    rst = 1'b0;
    tick(2);

    // R2: first trial is midpoint
    temp_i = 7'd93; settle_i = 4'd2;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
    @(negedge clk);
    chk(thr_code_o == 7'd64, "R2", "first trial", thr_code_o, 64);
    chk(thr_valid_o == 1'b0, "R3", "valid cleared by write", thr_valid_o, 0);
    wait_end(d);
    chk(code_o == 7'd93, "R4", "binary search result 93", code_o, 93);

    // R4 R5: code range ends and midpoint neighbours, varied settle
    search(0, 0, 0, "R5");
    search(127, 0, 0, "R5");
    search(64, 0, 5, "R4");
    search(63, 0, 3, "R4");
    search(1, 0, 15, "R3");

    // R8: other power modes
    sysclk_live_i = 1'b0;
    search(45, 1, 1, "R8");
    search(100, 2, 0, "R8");
    sysclk_live_i = 1'b1;
    search(17, 3, 2, "R8");

    // R6: interrupt enable requested throughout; masked only while busy
    irq_en_i = 1'b1; pwr_mode_i = 2'd0;
    search(80, 0, 1, "R6");
    tick(3);
    chk(thr_ie_o == 1'b1, "R6", "ie restored when idle", thr_ie_o, 1);
    chk(thermal_irq_o == (temp_i >= thr_code_o), "R6", "idle irq",
        thermal_irq_o, temp_i >= thr_code_o);
    irq_en_i = 1'b0;

    // R7: extra starts during a search
    temp_i = 7'd37; settle_i = 4'd3;
    pulse_start();
    tick(5);
    pulse_start();
    tick(11);
    pulse_start();
    wait_end(d);
    chk(d && code_o == 7'd37, "R7", "code unaffected by mid-search start", code_o, 37);

    // R9: clock lost in sleep mid-search
    temp_i = 7'd110; settle_i = 4'd4; pwr_mode_i = 2'd3; sysclk_live_i = 1'b1;
    pulse_start();
    tick(4);
    sysclk_live_i = 1'b0;
    wait_end(d);
    chk(!d, "R9", "search aborted", d, 0);
    chk(busy_o == 1'b0, "R9", "busy dropped on abort", busy_o, 0);
    chk(code_o == 7'd37, "R9", "code kept on abort", code_o, 37);
    tick(25);
    chk(thr_valid_o == 1'b0, "R9", "no valid while clock static", thr_valid_o, 0);

    // R10: start while inactive
    pulse_start();
    chk(busy_o == 1'b0, "R10", "no search while inactive", busy_o, 0);
    tick(3);
    chk(busy_o == 1'b0 && thr_valid_o == 1'b0, "R10", "still idle", busy_o, 0);

    // R8: clock restored, comparator resumes
    sysclk_live_i = 1'b1;
    search(5, 3, 0, "R8");

    tick(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule